// File: doc/BRIEF.md
# Mode-Banked Register File Controller

This block holds the integer and floating-point register state of a processor core. It provides sixteen 32-bit integer registers and thirty-two 32-bit float registers. The lower eight integer registers exist twice. The float registers form two banks of sixteen. Which copy the core sees is decided by the status word (SR) and the floating-point control word (FPSCR), and both live in this block. The core reads and writes the visible copy through one integer port and one float port. Instruction decode and the ALU sit elsewhere.

The integer bank follows two SR bits: the privilege bit and the bank-select bit. The float bank follows the FR bit of FPSCR. A bank change does not move any data. Each register set keeps a one-bit physical selector, and that selector toggles only when the effective choice of bank actually changes.

The T, S, M and Q condition flags are kept as four separate bits, so the ALU can update them without rewriting SR. An SR read rebuilds the full word from those flags and the stored bits.

A debug port reaches either copy by its absolute bank number, whichever copy is visible at the time. A 3-bit mode output gives the privilege, transfer-size and precision bits together.

Top module: `bankreg_file`

## Requirements
- R1: After reset:
  - SR reads 0x700000F0.
  - FPSCR reads 0x00040001.
  - The mode output is 3'b100.
  - Every integer and float register reads zero.
- R2: Integer bank 1 of R0–R7 is the visible bank only when SR bit 30 (privilege) and SR bit 29 (bank select) are both 1. Otherwise bank 0 is visible.
- R3: An SR write changes the visible R0–R7 copy only when the effective bank changes.
  - The new view appears on the read port in the cycle after the write.
  - An integer register write issued in the same cycle as an SR write lands in the bank that was visible before that SR write.
- R4: SR keeps only the bits set in 0x700083F3. All other bits read zero, and a write is read back masked in the next cycle.
- R5: The flag port loads flagWrData = {Q,M,S,T} into the separate flag bits. An SR read returns them at bit 8 (Q), bit 9 (M), bit 1 (S) and bit 0 (T). When an SR write and a flag write happen in the same cycle, the SR write wins.
- R6: FPSCR keeps only the bits set in 0x003FFFFF.
- R7: The float read and write ports address the bank selected by FPSCR bit 21 (FR).
  - An FPSCR write that toggles FR swaps the two float banks, effective in the next cycle.
  - An FPSCR write that leaves FR unchanged leaves the visible float contents unchanged.
- R8: Integer registers R8–R15 are not banked. They hold the same contents in every mode.
- R9: The debug address is {float select [5], absolute bank [4], index [3:0]}.
  - With float select 0, indices 0–7 return that absolute integer bank's copy of R0–R7, and indices 8–15 return the shared register.
  - With float select 1, the port returns that absolute float bank's entry.
- R10: modeOut = {SR bit 30, FPSCR bit 20 (transfer size), FPSCR bit 19 (precision)}. It is registered, and it shows the written values in the cycle after any SR or FPSCR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gprWrEn | input | 1 | Integer register write strobe |
| gprWrAddr | input | 4 | Integer register write index (visible view) |
| gprWrData | input | 32 | Integer write data |
| gprRdAddr | input | 4 | Integer register read index (visible view) |
| gprRdData | output | 32 | Integer read data |
| fprWrEn | input | 1 | Float register write strobe |
| fprWrAddr | input | 4 | Float register write index (visible bank) |
| fprWrData | input | 32 | Float write data |
| fprRdAddr | input | 4 | Float register read index (visible bank) |
| fprRdData | output | 32 | Float read data |
| srWrEn | input | 1 | SR write strobe |
| srWrData | input | 32 | SR write value |
| srRdData | output | 32 | SR with live flags merged |
| flagWrEn | input | 1 | Condition flag update strobe |
| flagWrData | input | 4 | New flags {Q,M,S,T} |
| fpscrWrEn | input | 1 | FPSCR write strobe |
| fpscrWrData | input | 32 | FPSCR write value |
| fpscrRdData | output | 32 | FPSCR contents |
| modeOut | output | 3 | {privilege, transfer size, precision} |
| dbgAddr | input | 6 | Debug address {float, absolute bank, index} |
| dbgData | output | 32 | Debug read data |

## Verification
Every write strobe is sampled at one rising edge. All read ports, including SR, FPSCR and debug, are combinational views of the registered state, so each result is due in the very next cycle, and a bank swap shows up there too. The mode output is a register loaded at that same edge, so it is also due one cycle after the write. The bench applies each write for exactly one clock and drops the strobe at the falling edge. Its monitor sets the probe address and samples one nanosecond after that falling edge, which is the first point where the result is due and well clear of the next rising edge.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int XLEN = 32;

  // Status word bit positions
  localparam int SR_T  = 0;
  localparam int SR_S  = 1;
  localparam int SR_Q  = 8;
  localparam int SR_M  = 9;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;

  // Float control bit positions
  localparam int FP_PR = 19;
  localparam int FP_SZ = 20;
  localparam int FP_FR = 21;

  localparam logic [XLEN-1:0] SR_KEEP     = 32'h7000_83F3;
  localparam logic [XLEN-1:0] FPSCR_KEEP  = 32'h003F_FFFF;
  localparam logic [XLEN-1:0] SR_RESET    = 32'h7000_00F0;
  localparam logic [XLEN-1:0] FPSCR_RESET = 32'h0004_0001;
  localparam logic [XLEN-1:0] FLAG_BITS   = (32'd1 << SR_T) | (32'd1 << SR_S) |
                                            (32'd1 << SR_Q) | (32'd1 << SR_M);

  // Bank selection handed from control to datapath
  typedef struct packed {
    logic intPhys;  // physical integer array currently visible
    logic intAbs;   // absolute integer bank currently visible
    logic fpPhys;   // physical float array currently visible
    logic fpAbs;    // absolute float bank currently visible
  } bankSel_t;
endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            srWrEn,
  input  logic [XLEN-1:0] srWrData,
  input  logic            flagWrEn,
  input  logic [3:0]      flagWrData,
  input  logic            fpscrWrEn,
  input  logic [XLEN-1:0] fpscrWrData,
  output logic [XLEN-1:0] srRdData,
  output logic [XLEN-1:0] fpscrRdData,
  output logic [2:0]      modeOut,
  output bankSel_t        sel
);
  logic [XLEN-1:0] srRest;
  logic [XLEN-1:0] fpscrQ;
  logic            flagT, flagS, flagM, flagQ;
  logic            intPhysQ, fpPhysQ;
  logic [2:0]      modeQ;

  logic [XLEN-1:0] srMasked, fpMasked, fpNext;
  logic            curIntAbs, newIntAbs, intSwap, fpSwap, mdNext;

  always_comb begin
    srMasked  = srWrData & SR_KEEP;
    fpMasked  = fpscrWrData & FPSCR_KEEP;
    curIntAbs = srRest[SR_MD] & srRest[SR_RB];
    newIntAbs = srMasked[SR_MD] & srMasked[SR_RB];
    intSwap   = srWrEn && (curIntAbs != newIntAbs);
    fpSwap    = fpscrWrEn && (fpscrQ[FP_FR] != fpMasked[FP_FR]);
    mdNext    = srWrEn ? srMasked[SR_MD] : srRest[SR_MD];
    fpNext    = fpscrWrEn ? fpMasked : fpscrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srRest   <= SR_RESET & ~FLAG_BITS;
      flagT    <= SR_RESET[SR_T];
      flagS    <= SR_RESET[SR_S];
      flagM    <= SR_RESET[SR_M];
      flagQ    <= SR_RESET[SR_Q];
      fpscrQ   <= FPSCR_RESET;
      intPhysQ <= 1'b0;
      fpPhysQ  <= 1'b0;
      modeQ    <= {SR_RESET[SR_MD], FPSCR_RESET[FP_SZ], FPSCR_RESET[FP_PR]};
    end else begin
      if (srWrEn) begin
        srRest <= srMasked & ~FLAG_BITS;
        flagT  <= srMasked[SR_T];
        flagS  <= srMasked[SR_S];
        flagM  <= srMasked[SR_M];
        flagQ  <= srMasked[SR_Q];
      end else if (flagWrEn) begin
        {flagQ, flagM, flagS, flagT} <= flagWrData;
      end
      if (intSwap)   intPhysQ <= ~intPhysQ;
      if (fpSwap)    fpPhysQ  <= ~fpPhysQ;
      if (fpscrWrEn) fpscrQ   <= fpMasked;
      if (srWrEn || fpscrWrEn) modeQ <= {mdNext, fpNext[FP_SZ], fpNext[FP_PR]};
    end
  end

  assign srRdData = srRest | (XLEN'(flagT) << SR_T) | (XLEN'(flagS) << SR_S) |
                    (XLEN'(flagQ) << SR_Q) | (XLEN'(flagM) << SR_M);
  assign fpscrRdData = fpscrQ;
  assign modeOut     = modeQ;

  assign sel.intPhys = intPhysQ;
  assign sel.intAbs  = curIntAbs;
  assign sel.fpPhys  = fpPhysQ;
  assign sel.fpAbs   = fpscrQ[FP_FR];
endmodule

// File: rtl/bankreg_dp.sv
module bankreg_dp
  import bankreg_pkg::*;
#(
  parameter  int NUM_GPR = 16,
  parameter  int BANKED  = 8,
  parameter  int NUM_FPR = 16,
  localparam int GPR_AW  = $clog2(NUM_GPR),
  localparam int FPR_AW  = $clog2(NUM_FPR),
  localparam int IDX_AW  = (GPR_AW > FPR_AW) ? GPR_AW : FPR_AW,
  localparam int DBG_AW  = IDX_AW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankSel_t          sel,
  input  logic              gprWrEn,
  input  logic [GPR_AW-1:0] gprWrAddr,
  input  logic [XLEN-1:0]   gprWrData,
  input  logic [GPR_AW-1:0] gprRdAddr,
  output logic [XLEN-1:0]   gprRdData,
  input  logic              fprWrEn,
  input  logic [FPR_AW-1:0] fprWrAddr,
  input  logic [XLEN-1:0]   fprWrData,
  input  logic [FPR_AW-1:0] fprRdAddr,
  output logic [XLEN-1:0]   fprRdData,
  input  logic [DBG_AW-1:0] dbgAddr,
  output logic [XLEN-1:0]   dbgData
);
  localparam int BANK_AW = (BANKED > 1) ? $clog2(BANKED) : 1;

  logic [XLEN-1:0] lowBank [2][BANKED];
  logic [XLEN-1:0] fprBank [2][NUM_FPR];
  logic [XLEN-1:0] highRd, highDbg;

  logic              wrIsLow, rdIsLow, dbgIsLow;
  logic              dbgFloat, dbgBank, intDbgPhys, fpDbgPhys;
  logic [IDX_AW-1:0] dbgIdx;

  assign wrIsLow    = gprWrAddr < GPR_AW'(BANKED);
  assign rdIsLow    = gprRdAddr < GPR_AW'(BANKED);
  assign dbgFloat   = dbgAddr[DBG_AW-1];
  assign dbgBank    = dbgAddr[DBG_AW-2];
  assign dbgIdx     = dbgAddr[IDX_AW-1:0];
  assign dbgIsLow   = dbgIdx < IDX_AW'(BANKED);
  assign intDbgPhys = (dbgBank == sel.intAbs) ? sel.intPhys : ~sel.intPhys;
  assign fpDbgPhys  = (dbgBank == sel.fpAbs) ? sel.fpPhys : ~sel.fpPhys;

  // Banked low integer registers: writes go to the currently visible array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < BANKED; i++)
          lowBank[b][i] <= '0;
    end else if (gprWrEn && wrIsLow) begin
      lowBank[sel.intPhys][gprWrAddr[BANK_AW-1:0]] <= gprWrData;
    end
  end

  // Float registers, two physical arrays
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_FPR; i++)
          fprBank[b][i] <= '0;
    end else if (fprWrEn) begin
      fprBank[sel.fpPhys][fprWrAddr] <= fprWrData;
    end
  end

  // Unbanked upper integer registers, present only when the count allows
  generate
    if (NUM_GPR > BANKED) begin : gHigh
      logic [XLEN-1:0] highRegs [BANKED:NUM_GPR-1];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = BANKED; i < NUM_GPR; i++) highRegs[i] <= '0;
        end else if (gprWrEn && !wrIsLow) begin
          highRegs[gprWrAddr] <= gprWrData;
        end
      end
      assign highRd  = rdIsLow ? '0 : highRegs[gprRdAddr];
      assign highDbg = dbgIsLow ? '0 : highRegs[GPR_AW'(dbgIdx)];
    end else begin : gNoHigh
      assign highRd  = '0;
      assign highDbg = '0;
    end
  endgenerate

  always_comb begin
    gprRdData = rdIsLow ? lowBank[sel.intPhys][gprRdAddr[BANK_AW-1:0]] : highRd;
    fprRdData = fprBank[sel.fpPhys][fprRdAddr];
    if (dbgFloat)
      dbgData = fprBank[fpDbgPhys][FPR_AW'(dbgIdx)];
    else if (dbgIsLow)
      dbgData = lowBank[intDbgPhys][dbgIdx[BANK_AW-1:0]];
    else
      dbgData = highDbg;
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter  int NUM_GPR = 16,
  parameter  int BANKED  = 8,
  parameter  int NUM_FPR = 16,
  localparam int GPR_AW  = $clog2(NUM_GPR),
  localparam int FPR_AW  = $clog2(NUM_FPR),
  localparam int IDX_AW  = (GPR_AW > FPR_AW) ? GPR_AW : FPR_AW,
  localparam int DBG_AW  = IDX_AW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gprWrEn,
  input  logic [GPR_AW-1:0] gprWrAddr,
  input  logic [31:0]       gprWrData,
  input  logic [GPR_AW-1:0] gprRdAddr,
  output logic [31:0]       gprRdData,
  input  logic              fprWrEn,
  input  logic [FPR_AW-1:0] fprWrAddr,
  input  logic [31:0]       fprWrData,
  input  logic [FPR_AW-1:0] fprRdAddr,
  output logic [31:0]       fprRdData,
  input  logic              srWrEn,
  input  logic [31:0]       srWrData,
  output logic [31:0]       srRdData,
  input  logic              flagWrEn,
  input  logic [3:0]        flagWrData,
  input  logic              fpscrWrEn,
  input  logic [31:0]       fpscrWrData,
  output logic [31:0]       fpscrRdData,
  output logic [2:0]        modeOut,
  input  logic [DBG_AW-1:0] dbgAddr,
  output logic [31:0]       dbgData
);
  bankSel_t sel;

  bankreg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .srWrEn      (srWrEn),
    .srWrData    (srWrData),
    .flagWrEn    (flagWrEn),
    .flagWrData  (flagWrData),
    .fpscrWrEn   (fpscrWrEn),
    .fpscrWrData (fpscrWrData),
    .srRdData    (srRdData),
    .fpscrRdData (fpscrRdData),
    .modeOut     (modeOut),
    .sel         (sel)
  );

  bankreg_dp #(
    .NUM_GPR (NUM_GPR),
    .BANKED  (BANKED),
    .NUM_FPR (NUM_FPR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sel       (sel),
    .gprWrEn   (gprWrEn),
    .gprWrAddr (gprWrAddr),
    .gprWrData (gprWrData),
    .gprRdAddr (gprRdAddr),
    .gprRdData (gprRdData),
    .fprWrEn   (fprWrEn),
    .fprWrAddr (fprWrAddr),
    .fprWrData (fprWrData),
    .fprRdAddr (fprRdAddr),
    .fprRdData (fprRdData),
    .dbgAddr   (dbgAddr),
    .dbgData   (dbgData)
  );
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
  import bankreg_pkg::*;
#(
  parameter int GPR_AW = 4,
  parameter int FPR_AW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              srWrEn,
  input logic [31:0]       srWrData,
  input logic [31:0]       srRdData,
  input logic              flagWrEn,
  input logic [3:0]        flagWrData,
  input logic              fpscrWrEn,
  input logic [31:0]       fpscrWrData,
  input logic [31:0]       fpscrRdData,
  input logic [2:0]        modeOut,
  input logic              gprWrEn,
  input logic [GPR_AW-1:0] gprRdAddr,
  input logic [31:0]       gprRdData,
  input logic              fprWrEn,
  input logic [FPR_AW-1:0] fprRdAddr,
  input logic [31:0]       fprRdData
);
  AST_SR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (srRdData & ~SR_KEEP) == 32'd0); // R4

  AST_SR_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    srWrEn |=> srRdData == ($past(srWrData) & SR_KEEP)); // R5

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && !srWrEn) |=>
      {srRdData[SR_Q], srRdData[SR_M], srRdData[SR_S], srRdData[SR_T]} == $past(flagWrData)); // R5

  AST_FPSCR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (fpscrRdData & ~FPSCR_KEEP) == 32'd0); // R6

  AST_MODE_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == {srRdData[SR_MD], fpscrRdData[FP_SZ], fpscrRdData[FP_PR]}); // R10

  AST_INT_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (srWrEn && !gprWrEn &&
     ((srWrData[SR_MD] & srWrData[SR_RB]) == (srRdData[SR_MD] & srRdData[SR_RB]))) |=>
      ((gprRdAddr != $past(gprRdAddr)) || $stable(gprRdData))); // R3

  AST_FP_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fpscrWrEn && !fprWrEn && (fpscrWrData[FP_FR] == fpscrRdData[FP_FR])) |=>
      ((fprRdAddr != $past(fprRdAddr)) || $stable(fprRdData))); // R7
endmodule

bind bankreg_file bankreg_file_chk #(.GPR_AW(GPR_AW), .FPR_AW(FPR_AW)) u_chk (.*);

// File: tb/bankreg_file_tb.sv
module bankreg_file_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        gprWrEn = 1'b0, fprWrEn = 1'b0, srWrEn = 1'b0, flagWrEn = 1'b0, fpscrWrEn = 1'b0;
  logic [3:0]  gprWrAddr = '0, gprRdAddr = '0, fprWrAddr = '0, fprRdAddr = '0, flagWrData = '0;
  logic [31:0] gprWrData = '0, fprWrData = '0, srWrData = '0, fpscrWrData = '0;
  logic [5:0]  dbgAddr = '0;
  logic [31:0] gprRdData, fprRdData, srRdData, fpscrRdData, dbgData;
  logic [2:0]  modeOut;

  always #4 clk = ~clk; // 125 MHz

  bankreg_file u_dut (
    .clk(clk), .rstN(rstN),
    .gprWrEn(gprWrEn), .gprWrAddr(gprWrAddr), .gprWrData(gprWrData),
    .gprRdAddr(gprRdAddr), .gprRdData(gprRdData),
    .fprWrEn(fprWrEn), .fprWrAddr(fprWrAddr), .fprWrData(fprWrData),
    .fprRdAddr(fprRdAddr), .fprRdData(fprRdData),
    .srWrEn(srWrEn), .srWrData(srWrData), .srRdData(srRdData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .fpscrWrEn(fpscrWrEn), .fpscrWrData(fpscrWrData), .fpscrRdData(fpscrRdData),
    .modeOut(modeOut), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  // Probe kinds
  localparam int P_GPR = 0, P_FPR = 1, P_DBG = 2, P_SR = 3, P_FPSCR = 4, P_MODE = 5;

  int          nChecks = 0, nFails = 0, pending = 0;
  bit          finished = 1'b0;
  int          qKind[$];
  int          qAddr[$];
  logic [31:0] qExp[$];
  string       qReq[$];

  // Driver side of the scoreboard
  task automatic expectVal(input int kind, input int addr, input logic [31:0] exp, input string req);
    qKind.push_back(kind);
    qAddr.push_back(addr);
    qExp.push_back(exp);
    qReq.push_back(req);
    pending++;
    wait (pending == 0);
  endtask

  // Monitor: pops an expected item, points the probe, samples clear of the edge
  int          mKind, mAddr;
  logic [31:0] mExp, mAct;
  string       mReq;
  initial begin
    forever begin
      wait (pending > 0);
      mKind = qKind.pop_front();
      mAddr = qAddr.pop_front();
      mExp  = qExp.pop_front();
      mReq  = qReq.pop_front();
      case (mKind)
        P_GPR:   gprRdAddr = mAddr[3:0];
        P_FPR:   fprRdAddr = mAddr[3:0];
        P_DBG:   dbgAddr   = mAddr[5:0];
        default: ;
      endcase
      #1;
      case (mKind)
        P_GPR:   mAct = gprRdData;
        P_FPR:   mAct = fprRdData;
        P_DBG:   mAct = dbgData;
        P_SR:    mAct = srRdData;
        P_FPSCR: mAct = fpscrRdData;
        default: mAct = {29'd0, modeOut};
      endcase
      nChecks++;
      if (mAct !== mExp) begin
        nFails++;
        $display("FAIL %s: probe %0d addr %0d actual=%h expected=%h", mReq, mKind, mAddr, mAct, mExp);
      end
      pending--;
    end
  end

  task automatic gprWrite(input int a, input logic [31:0] d);
    @(negedge clk); gprWrEn = 1'b1; gprWrAddr = a[3:0]; gprWrData = d;
    @(negedge clk); gprWrEn = 1'b0;
  endtask
  task automatic fprWrite(input int a, input logic [31:0] d);
    @(negedge clk); fprWrEn = 1'b1; fprWrAddr = a[3:0]; fprWrData = d;
    @(negedge clk); fprWrEn = 1'b0;
  endtask
  task automatic srWrite(input logic [31:0] v);
    @(negedge clk); srWrEn = 1'b1; srWrData = v;
    @(negedge clk); srWrEn = 1'b0;
  endtask
  task automatic fpscrWrite(input logic [31:0] v);
    @(negedge clk); fpscrWrEn = 1'b1; fpscrWrData = v;
    @(negedge clk); fpscrWrEn = 1'b0;
  endtask
  task automatic flagWrite(input logic [3:0] f);
    @(negedge clk); flagWrEn = 1'b1; flagWrData = f;
    @(negedge clk); flagWrEn = 1'b0;
  endtask
  task automatic srWithGpr(input logic [31:0] v, input int a, input logic [31:0] d);
    @(negedge clk); srWrEn = 1'b1; srWrData = v; gprWrEn = 1'b1; gprWrAddr = a[3:0]; gprWrData = d;
    @(negedge clk); srWrEn = 1'b0; gprWrEn = 1'b0;
  endtask
  task automatic srWithFlag(input logic [31:0] v, input logic [3:0] f);
    @(negedge clk); srWrEn = 1'b1; srWrData = v; flagWrEn = 1'b1; flagWrData = f;
    @(negedge clk); srWrEn = 1'b0; flagWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectVal(P_SR,    0, 32'h7000_00F0, "R1");
    expectVal(P_FPSCR, 0, 32'h0004_0001, "R1");
    expectVal(P_MODE,  0, 32'd4,         "R1");
    expectVal(P_GPR,   0, 32'd0,         "R1");
    expectVal(P_DBG,   0, 32'd0,         "R1");

    // R2 bank 1 visible out of reset (MD=1, RB=1)
    gprWrite(0, 32'hA1A1_0000);
    expectVal(P_GPR, 0,  32'hA1A1_0000, "R2");
    expectVal(P_DBG, 16, 32'hA1A1_0000, "R9");
    expectVal(P_DBG, 0,  32'd0,         "R9");

    // MD=1, RB=0: bank 0 visible
    srWrite(32'h4000_0000);
    expectVal(P_GPR,  0, 32'd0,         "R2");
    expectVal(P_SR,   0, 32'h4000_0000, "R4");
    expectVal(P_MODE, 0, 32'd4,         "R10");
    gprWrite(0, 32'hB0B0_0000);
    expectVal(P_DBG, 0,  32'hB0B0_0000, "R9");
    expectVal(P_DBG, 16, 32'hA1A1_0000, "R9");

    // MD=0, RB=1: still bank 0, no swap
    srWrite(32'h2000_0000);
    expectVal(P_GPR,  0, 32'hB0B0_0000, "R3");
    expectVal(P_MODE, 0, 32'd0,         "R10");

    // Unbanked register, then back to bank 1
    gprWrite(9, 32'hC9C9_0000);
    srWrite(32'h6000_0000);
    expectVal(P_GPR, 0,  32'hA1A1_0000, "R3");
    expectVal(P_GPR, 9,  32'hC9C9_0000, "R8");
    expectVal(P_DBG, 9,  32'hC9C9_0000, "R8");
    expectVal(P_DBG, 25, 32'hC9C9_0000, "R9");

    // R3 same-cycle write lands in the old bank (bank 1)
    srWithGpr(32'h0000_0000, 1, 32'hD1D1_0000);
    expectVal(P_GPR, 1,  32'd0,         "R3");
    expectVal(P_DBG, 17, 32'hD1D1_0000, "R3");
    expectVal(P_DBG, 1,  32'd0,         "R3");

    // R4 masking
    srWrite(32'hFFFF_FFFF);
    expectVal(P_SR,  0, 32'h7000_83F3, "R4");
    expectVal(P_GPR, 1, 32'hD1D1_0000, "R2");

    // R5 flag port {Q,M,S,T}
    flagWrite(4'b0000);
    expectVal(P_SR, 0, 32'h7000_80F0, "R5");
    flagWrite(4'b0101);
    expectVal(P_SR,  0, 32'h7000_82F1, "R5");
    expectVal(P_GPR, 1, 32'hD1D1_0000, "R5");
    srWithFlag(32'h0000_0300, 4'b0001);
    expectVal(P_SR, 0, 32'h0000_0300, "R5");

    // R6 / R7 float control and banks
    fprWrite(3, 32'hE3E3_0000);
    expectVal(P_FPR, 3, 32'hE3E3_0000, "R7");
    fpscrWrite(32'hFFFF_FFFF);
    expectVal(P_FPSCR, 0,  32'h003F_FFFF, "R6");
    expectVal(P_MODE,  0,  32'd3,         "R10");
    expectVal(P_FPR,   3,  32'd0,         "R7");
    expectVal(P_DBG,   35, 32'hE3E3_0000, "R9");
    fprWrite(3, 32'hF3F3_0000);
    expectVal(P_DBG,   51, 32'hF3F3_0000, "R9");
    fpscrWrite(32'h0020_0000);
    expectVal(P_FPSCR, 0, 32'h0020_0000, "R6");
    expectVal(P_FPR,   3, 32'hF3F3_0000, "R7");
    expectVal(P_MODE,  0, 32'd0,         "R10");
    fpscrWrite(32'h0000_0000);
    expectVal(P_FPR, 3, 32'hE3E3_0000, "R7");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule